// File: doc/BRIEF.md
# Saturating SIMD Lane Pack Unit

This block narrows two 64-bit media operands into one 64-bit result. Each operand holds signed lanes of a selectable width (16, 32 or 64 bits). Every lane is reduced to half its width and clamped into the destination range, so a value that does not fit becomes the nearest limit instead of wrapping. The lanes of the first operand fill the low half of the result and the lanes of the second operand fill the high half. In both halves the lanes keep their original order.

A mode input chooses the destination range. In signed mode the range is the two's-complement range of the narrow lane. In unsigned mode the range runs from zero to all ones. The narrowing itself is combinational. The result and a valid flag are registered once, so a datapath stage can issue one operation per clock and see the packed word on the following cycle.

Top module: `simd_pack_sat`

## Requirements
- R1: The size code `size_sel` selects the source lane width and the destination lane width. Code 0 gives 16-bit source lanes and 8-bit destination lanes. Code 1 gives 32-bit source lanes and 16-bit destination lanes. Code 2 gives 64-bit source lanes and 32-bit destination lanes. Code 3 behaves like code 2. Every bit of the result is written.
- R2: The result has 64/DW destination lanes, where DW is the destination lane width. Lane 0 occupies bits DW-1:0. Lanes 0 to N/2-1 come from `src_a` lanes 0 to N/2-1, and lanes N/2 to N-1 come from `src_b` lanes 0 to N/2-1.
- R3: Each source lane is read as a two's-complement number whose top bit is the sign. In signed mode (`sat_signed`=1), a lane inside the range -2^(DW-1) to 2^(DW-1)-1 is passed through as its low DW bits.
- R4: In signed mode, a lane below -2^(DW-1) becomes 1 followed by DW-1 zeros. A lane above 2^(DW-1)-1 becomes 0 followed by DW-1 ones.
- R5: In unsigned mode (`sat_signed`=0), any negative source lane becomes 0.
- R6: In unsigned mode, a non-negative lane above 2^DW-1 becomes all ones in DW bits. Lanes from 0 to 2^DW-1 pass through unchanged, including those from 2^(DW-1) up.
- R7: When `in_valid` is high at a rising clock edge, `result` takes the packed value of that cycle's inputs and `out_valid` is high for the following cycle. `out_valid` is low in any cycle after an edge where `in_valid` was low.
- R8: When `in_valid` is low at an edge, `result` keeps its previous value whatever the other inputs do.
- R9: While `rst_n` is low, `out_valid` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| src_a | input | 64 | First operand, fills the low half of the result |
| src_b | input | 64 | Second operand, fills the high half of the result |
| size_sel | input | 2 | Lane width code (see R1) |
| sat_signed | input | 1 | 1 selects signed saturation, 0 selects unsigned saturation |
| out_valid | output | 1 | Registered result is valid |
| result | output | 64 | Registered packed result |

## Verification
The bench builds the unit with its default 64-bit data width. At that width all three lane sizes exist at once, so the 8-, 16- and 32-bit destination ranges are checked against the same reference. For each size the bench drives the exact values min, max, min-1 and max+1, plus the unsigned edge between 2^(DW-1) and 2^DW. A 64-bit source lane at its full extremes is included to reach the widest clamp path.

// File: rtl/simd_pack_sat.sv
module simd_pack_sat #(
  parameter int DATA_W    = 64,
  parameter int NUM_SIZES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [1:0]        size_sel,
  input  logic              sat_signed,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] cand [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int SW = DATA_W >> (NUM_SIZES - 1 - g);
    localparam int DW = SW / 2;
    localparam int NL = DATA_W / DW;
    localparam int HL = NL / 2;

    for (genvar l = 0; l < NL; l++) begin : g_lane
      localparam int J = l % HL;
      logic [SW-1:0] x;
      logic          sgn, fit_s, fit_u;
      logic [DW-1:0] y_s, y_u;

      if (l < HL) begin : g_lo
        assign x = src_a[J*SW +: SW];
      end else begin : g_hi
        assign x = src_b[J*SW +: SW];
      end

      assign sgn   = x[SW-1];
      assign fit_s = (x[SW-1:DW-1] == {(SW-DW+1){sgn}});
      assign fit_u = ~|x[SW-1:DW];
      assign y_s   = fit_s ? x[DW-1:0] : (sgn ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}});
      assign y_u   = sgn ? '0 : (fit_u ? x[DW-1:0] : '1);
      assign cand[g][l*DW +: DW] = sat_signed ? y_s : y_u;
    end
  end

  logic [DATA_W-1:0] packed_w;
  always_comb begin
    if (int'(size_sel) >= NUM_SIZES) packed_w = cand[NUM_SIZES-1];
    else                             packed_w = cand[size_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= packed_w;
    end
  end

endmodule

module simd_pack_sat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] src_a,
  input logic [1:0]  size_sel,
  input logic        sat_signed,
  input logic        out_valid,
  input logic [63:0] result
);

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  // R5
  unsigned_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sat_signed && size_sel[1] && src_a[63]) |=> (result[31:0] == 32'h0));

  // R3
  signed_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_signed && size_sel[1] && ((&src_a[63:31]) || !(|src_a[63:31])))
    |=> (result[31:0] == $past(src_a[31:0])));

endmodule

bind simd_pack_sat simd_pack_sat_chk u_chk (.*);

// File: tb/tb_simd_pack_sat.sv
module tb_simd_pack_sat;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  localparam logic [130:0] VECS [NVEC] = '{
    {2'd0, 1'b1, 64'hFF7F_FF80_0080_007F, 64'h00FF_0100_8000_7FFF},
    {2'd0, 1'b0, 64'hFF7F_FF80_0080_007F, 64'h00FF_0100_8000_7FFF},
    {2'd0, 1'b1, 64'h0001_FFFF_0042_FFC0, 64'h0000_0003_FFFE_0010},
    {2'd0, 1'b0, 64'h0001_FFFF_0042_00C0, 64'h0000_0003_FFFE_00FE},
    {2'd1, 1'b1, 64'hFFFF7FFF_FFFF8000, 64'h00008000_00007FFF},
    {2'd1, 1'b0, 64'hFFFF7FFF_0000FFFF, 64'h00010000_00008000},
    {2'd1, 1'b1, 64'h12345678_FFFFFFFE, 64'h80000000_00001234},
    {2'd2, 1'b1, 64'h00000000_7FFFFFFF, 64'h00000000_80000000},
    {2'd2, 1'b1, 64'hFFFFFFFF_80000000, 64'hFFFFFFFF_7FFFFFFF},
    {2'd2, 1'b1, 64'h80000000_00000000, 64'h7FFFFFFF_FFFFFFFF},
    {2'd2, 1'b0, 64'h00000000_FFFFFFFF, 64'h00000001_00000000},
    {2'd2, 1'b0, 64'h80000000_00000000, 64'h00000000_80000000},
    {2'd3, 1'b1, 64'hFFFFFFFF_7FFFFFFF, 64'h00000000_80000000},
    {2'd3, 1'b0, 64'hFFFFFFFF_FFFFFFFF, 64'h00000000_C0000000}
  };

  logic clk = 0, rst_n = 0, in_valid = 0, sat_signed = 0;
  logic [63:0] src_a = 0, src_b = 0;
  logic [1:0] size_sel = 0;
  logic out_valid;
  logic [63:0] result;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_pack_sat dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a),
    .src_b(src_b), .size_sel(size_sel), .sat_signed(sat_signed),
    .out_valid(out_valid), .result(result));

  function automatic logic [63:0] ref_pack(logic [1:0] sz, logic sm, logic [63:0] a, logic [63:0] b);
    int sw, dw, nl;
    logic [63:0] r, raw, msk;
    longint v, lo, hi;
    sw = (sz == 0) ? 16 : (sz == 1) ? 32 : 64;
    dw = sw / 2;
    nl = 64 / dw;
    msk = (64'd1 << dw) - 1;
    lo = sm ? -(longint'(1) <<< (dw-1)) : 0;
    hi = sm ? (longint'(1) <<< (dw-1)) - 1 : (longint'(1) <<< dw) - 1;
    r = 0;
    for (int i = 0; i < nl; i++) begin
      raw = (i < nl/2) ? (a >> (i*sw)) : (b >> ((i - nl/2)*sw));
      v = longint'(raw << (64 - sw));
      v = v >>> (64 - sw);
      if (v < lo) v = lo;
      if (v > hi) v = hi;
      r = r | ((64'(v) & msk) << (i*dw));
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(string tag, logic [1:0] sz, logic sm, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    size_sel = sz; sat_signed = sm; src_a = a; src_b = b; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check({tag, " out_valid R7"}, {63'd0, out_valid}, 64'd1);
    check(tag, result, ref_pack(sz, sm, a, b));
  endtask

  initial begin
    #(CLK_PERIOD*3);
    // R9
    check("R9 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R9 reset result", result, 64'd0);
    @(negedge clk) rst_n = 1;

    // R1 R2 R3 R4 R5 R6 over the table
    for (int k = 0; k < NVEC; k++)
      apply("R1/R2/R3/R4/R5/R6 table", VECS[k][130:129], VECS[k][128], VECS[k][127:64], VECS[k][63:0]);

    // R2 lane order, directed
    apply("R2 lane order", 2'd0, 1'b1, 64'h0004_0003_0002_0001, 64'h0008_0007_0006_0005);
    check("R2 lane order literal", result, 64'h0807_0605_0403_0201);
    // R4 directed
    apply("R4 signed clamp", 2'd1, 1'b1, 64'hFFFF7FFF_00008000, 64'h0);
    check("R4 signed clamp literal", result, 64'h0000_0000_8000_7FFF);
    // R5 R6 directed
    apply("R6 unsigned", 2'd0, 1'b0, 64'h0100_00FF_0080_FFFF, 64'h0);
    check("R6 unsigned literal", result, 64'h0000_0000_FFFF_8000);
    // R1 code 3 equals code 2
    apply("R1 code3", 2'd3, 1'b1, 64'h00000001_00000000, 64'hFFFFFFFE_FFFFFFFF);
    check("R1 code3 literal", result, 64'h80000000_7FFFFFFF);

    // R8 hold with in_valid low
    @(negedge clk);
    src_a = 64'h1111_2222_3333_4444; src_b = 64'h5555_6666_7777_8888; sat_signed = 0; size_sel = 0;
    @(negedge clk);
    check("R8 hold result", result, 64'h80000000_7FFFFFFF);
    check("R7 out_valid low", {63'd0, out_valid}, 64'd0);

    // R9 reset mid-run
    rst_n = 0;
    #1;
    check("R9 reset clears result", result, 64'd0);
    @(negedge clk) rst_n = 1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule